// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one memory-to-memory DMA channel. Software programs it through a small register port and sets a run bit. The channel then copies a byte count from a source address to a target address over a single-beat, word-wide memory port. Each access is held until the memory acknowledges it. An access may end in an error response.

The channel can take its transfer parameters straight from its registers, or it can walk a linked list of descriptors in memory. A descriptor is four 32-bit words at a 16-byte-aligned address, in this order: next pointer, source address, target address, command word. Bit 0 of the next pointer marks the last descriptor of the list. Data moves in bursts: the channel reads a whole burst into an internal buffer and then writes that burst out. Each access carries one, two or four bytes. Start, end, stop and bus-error events are reported in a control/status register and drive a single interrupt line.

Register map on `reg_addr`: 0 = control/status, 1 = next pointer, 2 = source address, 3 = target address, 4 = command word. Reading source, target and command returns their working values, which advance as the transfer runs.

Top module: `dmac_chan`

## Requirements
- R1: After reset the control/status register reads 0x00000008, meaning stopped = 1 and every other bit 0. `irq` and `mem_req` are low.
- R2: Writing control bit 31 = 1 while stopped, with bit 30 = 0, starts descriptor mode. The channel reads four words at (next pointer & ~0xF) + 0, 4, 8, 12, in that order, and loads them as next pointer, source, target and command.
- R3: The channel moves the byte count in command bits 12:0. It works in bursts of min(burst, remaining) bytes, and every read of a burst comes before any write of that burst. Command bits 17:16 give the burst size: 1 = 8, 2 = 16, 3 = 32 bytes, and 0 acts as 8. The count in bits 12:0 reads back as 0 when the transfer completes.
- R4: Command bits 15:14 give the access size: 1 = 1 byte, 2 = 2 bytes, 3 = 4 bytes, and 0 acts as 4. The last access carries any smaller remainder. Its byte enables start at address bits 1:0.
- R5: Command bit 31 makes the source address advance after each access, and bit 30 does the same for the target address. When a bit is clear, that address stays fixed.
- R6: When a descriptor completes, a clear bit 0 in its next pointer makes the channel fetch from (pointer & ~0xF). A set bit 0 halts the channel: run clears and stopped (bit 3) becomes 1.
- R7: Control bit 30 = 1 together with run selects no-descriptor mode. The transfer runs from the programmed source, target and command registers, and the channel halts when it completes.
- R8: Status bit 1 sets when a descriptor begins if command bit 22 is set. Status bit 2 sets when a descriptor completes if command bit 21 is set. Bits 2:0 clear when 1 is written to them. `irq` is the OR of status bits 2:0 with (stopped AND control bit 29).
- R9: An error response sets status bit 0, clears run and stops the channel. No further access is made, and the remaining count stays as it was.
- R10: Writing run = 0 while the channel is active stops it once the outstanding access has been acknowledged, with no end event.
- R11: Writes to the next, source, target and command registers are ignored while the channel is active.
- R12: A memory request keeps its address, direction and byte enables unchanged until it is acknowledged.
- R13: A descriptor with a byte count of 0 makes no data access, and its start and end events are still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 control, 1 next, 2 source, 3 target, 4 command) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 32 | Word-aligned access address |
| mem_be | output | 4 | Byte enables of the access |
| mem_wdata | output | 32 | Write data, byte lanes matching `mem_be` |
| mem_ack | input | 1 | Access completed this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the behaviour that must hold on every cycle:
- a pending request stays stable until it is acknowledged;
- every write carries at least one byte enable;
- an error response leaves the channel stopped with run clear and the error flag set;
- an active channel that has lost its run bit and has no access open reaches the stopped state one cycle later;
- a stopped channel with stop-interrupt enable set raises `irq`.

The bench's scenarios show what only a whole transfer can reveal. Each access, in order, is matched against a behavioural model: descriptor fetches with pointer masking, burst read/write grouping, lane placement for byte and halfword sizes with remainders, and fixed addresses. The scenarios also check the copied memory contents, chain termination, zero-length descriptors, register writes being ignored while active, and the status words after halts caused by an error or by software.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BEGIN,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } chan_state_e;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_NEXT = 3'd1;
    localparam logic [2:0] RA_SRC  = 3'd2;
    localparam logic [2:0] RA_TGT  = 3'd3;
    localparam logic [2:0] RA_CMD  = 3'd4;

    localparam int CB_SRC_INC  = 31;
    localparam int CB_TGT_INC  = 30;
    localparam int CB_START_EN = 22;
    localparam int CB_END_EN   = 21;

    localparam int SB_RUN     = 31;
    localparam int SB_NODESC  = 30;
    localparam int SB_STOPEN  = 29;
    localparam int SB_END     = 2;
    localparam int SB_START   = 1;
    localparam int SB_BUSERR  = 0;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [5:0] burst_bytes(input logic [1:0] code);
        case (code)
            2'd2:    return 6'd16;
            2'd3:    return 6'd32;
            default: return 6'd8;
        endcase
    endfunction

endpackage

// File: rtl/dmac_lane.sv
module dmac_lane (
    input  logic [2:0]  beat_bytes,
    input  logic [1:0]  src_lane,
    input  logic [1:0]  tgt_lane,
    input  logic [31:0] rd_word,
    input  logic [31:0] buf_word,
    output logic [3:0]  rd_be,
    output logic [3:0]  wr_be,
    output logic [31:0] rd_aligned,
    output logic [31:0] wr_word
);
    logic [3:0] span;

    always_comb begin
        case (beat_bytes)
            3'd1:    span = 4'b0001;
            3'd2:    span = 4'b0011;
            3'd3:    span = 4'b0111;
            default: span = 4'b1111;
        endcase
    end

    // addresses are aligned to the access size, so the shifted span stays in the word
    assign rd_be      = span << src_lane;
    assign wr_be      = span << tgt_lane;
    assign rd_aligned = rd_word >> {src_lane, 3'b000};
    assign wr_word    = buf_word << {tgt_lane, 3'b000};

endmodule

// File: rtl/dmac_burst_buf.sv
module dmac_burst_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_idx];

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
    parameter int BURST_MAX = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    import dmac_pkg::*;

    localparam int BUF_DEPTH = BURST_MAX;
    localparam int IW        = $clog2(BUF_DEPTH);
    localparam int CW        = $clog2(BURST_MAX + 1);

    typedef struct packed {
        chan_state_e     st;
        logic            run;
        logic            nodesc;
        logic            stopen;
        logic            ev_start;
        logic            ev_end;
        logic            ev_err;
        logic [31:0]     nxt;
        logic [31:0]     src;
        logic [31:0]     tgt;
        logic [31:0]     cmd;
        logic [31:0]     fbase;
        logic [1:0]      fidx;
        logic [IW-1:0]   bidx;
        logic [CW-1:0]   chunk;
        logic [CW-1:0]   left;
    } chan_t;

    chan_t q, d;

    logic [2:0]  wbytes;
    logic [12:0] cnt;
    logic [12:0] blim;
    logic [2:0]  nbeat;
    logic [12:0] cnt_after;
    logic [CW-1:0] chunk_now;
    logic [CW-1:0] chunk_after;
    logic        busy;
    logic        ok_ack;
    logic        stopped;
    logic        run;
    logic        stopen;
    logic        ev_err;
    logic        buf_we;
    logic [31:0] buf_rd;
    logic [31:0] rd_aligned;
    logic [31:0] wr_word;
    logic [3:0]  rd_be;
    logic [3:0]  wr_be;

    // ---------------- transfer arithmetic ----------------
    always_comb begin
        wbytes = width_bytes(q.cmd[15:14]);
        cnt    = q.cmd[12:0];
        if (BURST_MAX < int'(burst_bytes(q.cmd[17:16])))
            blim = 13'(BURST_MAX);
        else
            blim = 13'(burst_bytes(q.cmd[17:16]));
        if (q.left < CW'(wbytes))
            nbeat = q.left[2:0];
        else
            nbeat = wbytes;
        cnt_after   = cnt - 13'(nbeat);
        chunk_now   = (cnt < blim) ? CW'(cnt) : CW'(blim);
        chunk_after = (cnt_after < blim) ? CW'(cnt_after) : CW'(blim);
    end

    dmac_lane u_lane (
        .beat_bytes (nbeat),
        .src_lane   (q.src[1:0]),
        .tgt_lane   (q.tgt[1:0]),
        .rd_word    (mem_rdata),
        .buf_word   (buf_rd),
        .rd_be      (rd_be),
        .wr_be      (wr_be),
        .rd_aligned (rd_aligned),
        .wr_word    (wr_word)
    );

    assign buf_we = (q.st == ST_READ) && mem_ack && !mem_err;

    dmac_burst_buf #(
        .DEPTH (BUF_DEPTH),
        .W     (32)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (q.bidx),
        .wr_data (rd_aligned),
        .rd_idx  (q.bidx),
        .rd_data (buf_rd)
    );

    // ---------------- memory port ----------------
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        mem_be   = '0;
        case (q.st)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.fbase + {28'd0, q.fidx, 2'b00};
                mem_be   = 4'hF;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = {q.src[31:2], 2'b00};
                mem_be   = rd_be;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {q.tgt[31:2], 2'b00};
                mem_be   = wr_be;
            end
            default: ;
        endcase
    end

    assign mem_wdata = wr_word;
    assign busy      = (q.st != ST_IDLE);
    assign ok_ack    = mem_req && mem_ack && !mem_err;

    // ---------------- next-state ----------------
    always_comb begin
        d = q;

        // register port
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    d.stopen = reg_wdata[SB_STOPEN];
                    if (reg_wdata[SB_END])    d.ev_end   = 1'b0;
                    if (reg_wdata[SB_START])  d.ev_start = 1'b0;
                    if (reg_wdata[SB_BUSERR]) d.ev_err   = 1'b0;
                    if (!reg_wdata[SB_RUN]) begin
                        d.run = 1'b0;
                    end
                    if (!busy) begin
                        d.nodesc = reg_wdata[SB_NODESC];
                        if (reg_wdata[SB_RUN]) begin
                            d.run = 1'b1;
                            if (reg_wdata[SB_NODESC]) begin
                                d.st = ST_BEGIN;
                            end else begin
                                d.st    = ST_FETCH;
                                d.fidx  = 2'd0;
                                d.fbase = {q.nxt[31:4], 4'b0000};
                            end
                        end
                    end
                end
                RA_NEXT: if (!busy) d.nxt = reg_wdata;
                RA_SRC:  if (!busy) d.src = reg_wdata;
                RA_TGT:  if (!busy) d.tgt = reg_wdata;
                RA_CMD:  if (!busy) d.cmd = reg_wdata;
                default: ;
            endcase
        end

        // error response ends everything
        if (mem_req && mem_ack && mem_err) begin
            d.ev_err = 1'b1;
            d.run    = 1'b0;
        end

        case (q.st)
            ST_FETCH: begin
                if (ok_ack) begin
                    case (q.fidx)
                        2'd0: d.nxt = mem_rdata;
                        2'd1: d.src = mem_rdata;
                        2'd2: d.tgt = mem_rdata;
                        default: d.cmd = mem_rdata;
                    endcase
                    if (q.fidx == 2'd3) d.st = ST_BEGIN;
                    d.fidx = q.fidx + 2'd1;
                end
            end
            ST_BEGIN: begin
                if (q.cmd[CB_START_EN]) d.ev_start = 1'b1;
                if (cnt == 13'd0) begin
                    d.st = ST_FINISH;
                end else begin
                    d.st    = ST_READ;
                    d.chunk = chunk_now;
                    d.left  = chunk_now;
                    d.bidx  = '0;
                end
            end
            ST_READ: begin
                if (ok_ack) begin
                    if (q.cmd[CB_SRC_INC]) d.src = q.src + 32'(nbeat);
                    d.bidx = q.bidx + IW'(1);
                    d.left = q.left - CW'(nbeat);
                    if (q.left == CW'(nbeat)) begin
                        d.st   = ST_WRITE;
                        d.left = q.chunk;
                        d.bidx = '0;
                    end
                end
            end
            ST_WRITE: begin
                if (ok_ack) begin
                    if (q.cmd[CB_TGT_INC]) d.tgt = q.tgt + 32'(nbeat);
                    d.cmd[12:0] = cnt_after;
                    d.bidx = q.bidx + IW'(1);
                    d.left = q.left - CW'(nbeat);
                    if (q.left == CW'(nbeat)) begin
                        if (cnt_after == 13'd0) begin
                            d.st = ST_FINISH;
                        end else begin
                            d.st    = ST_READ;
                            d.chunk = chunk_after;
                            d.left  = chunk_after;
                            d.bidx  = '0;
                        end
                    end
                end
            end
            ST_FINISH: begin
                if (q.cmd[CB_END_EN]) d.ev_end = 1'b1;
                if (q.nodesc || q.nxt[0]) begin
                    d.run = 1'b0;
                end else begin
                    d.st    = ST_FETCH;
                    d.fidx  = 2'd0;
                    d.fbase = {q.nxt[31:4], 4'b0000};
                end
            end
            default: ;
        endcase

        // leave once run is gone and no access is open
        if (busy && !d.run && (!mem_req || mem_ack)) begin
            d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // ---------------- outputs ----------------
    assign stopped = (q.st == ST_IDLE);
    assign run     = q.run;
    assign stopen  = q.stopen;
    assign ev_err  = q.ev_err;
    assign irq     = q.ev_start | q.ev_end | q.ev_err | (q.stopen & stopped);

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {q.run, q.nodesc, q.stopen, 25'd0,
                                  stopped, q.ev_end, q.ev_start, q.ev_err};
            RA_NEXT: reg_rdata = q.nxt;
            RA_SRC:  reg_rdata = q.src;
            RA_TGT:  reg_rdata = q.tgt;
            RA_CMD:  reg_rdata = q.cmd;
            default: reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_err,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        irq,
    input logic        stopped,
    input logic        run,
    input logic        stopen,
    input logic        ev_err
);
    // R12
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

    // R4
    a_r4_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'b0000);

    // R9
    a_r9_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> stopped && !run && ev_err);

    // R10
    a_r10_run_loss_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !stopped && !mem_req |=> stopped);

    // R8
    a_r8_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && stopen |-> irq);

endmodule

bind dmac_chan dmac_chan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .irq      (irq),
    .stopped  (stopped),
    .run      (run),
    .stopen   (stopen),
    .ev_err   (ev_err)
);

// File: tb/dmac_chan_tb.sv
module dmac_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        irq;

    always #10 clk = ~clk;

    dmac_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } acc_t;

    logic [31:0] mem [int];
    acc_t        expq[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          lat = 1;
    bit          loose = 1'b0;
    int          err_lo = 32'h8000;
    int          err_hi = 32'h9000;

    function automatic logic [31:0] mrd(input int a);
        if (mem.exists(a >> 2)) return mem[a >> 2];
        return 32'd0;
    endfunction

    function automatic logic [7:0] mbyte(input int a);
        logic [31:0] w;
        w = mrd(a);
        return w[8*(a%4) +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- memory responder, compared every clock ----------------
    int          waitc = 0;
    bit          pend = 1'b0;
    logic [31:0] held_addr;

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (rst_n && mem_req) begin
            if (!pend) begin
                pend = 1'b1;
                held_addr = mem_addr;
                waitc = 0;
            end else begin
                chk("R12 held address", mem_addr, held_addr);
            end
            if (waitc < lat) begin
                waitc++;
            end else begin
                bit err;
                err = (int'(mem_addr) >= err_lo) && (int'(mem_addr) < err_hi);
                if (!loose) begin
                    if (expq.size() == 0) begin
                        chk("R3 unexpected access", mem_addr, 32'hFFFF_FFFF);
                    end else begin
                        acc_t e;
                        logic [31:0] m;
                        e = expq.pop_front();
                        m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
                        chk("R3 access address", mem_addr, e.addr);
                        chk("R3 access direction", {31'd0, mem_we}, {31'd0, e.we});
                        if (e.we) begin
                            chk("R4 write enables", {28'd0, mem_be}, {28'd0, e.be});
                            chk("R4 write data", mem_wdata & m, e.data & m);
                        end
                    end
                end
                if (mem_we && !err) begin
                    logic [31:0] w;
                    w = mrd(int'(mem_addr));
                    for (int k = 0; k < 4; k++)
                        if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
                    mem[int'(mem_addr) >> 2] = w;
                end
                mem_rdata = mrd(int'(mem_addr));
                mem_err = err;
                mem_ack = 1'b1;
                pend = 1'b0;
            end
        end
    end

    // ---------------- behavioural expectation model ----------------
    task automatic model_fetch(input int ptr);
        for (int i = 0; i < 4; i++) begin
            acc_t a;
            a.we = 0; a.addr = (ptr & ~15) + 4*i; a.data = 0; a.be = 4'hF;
            expq.push_back(a);
        end
    endtask

    task automatic model_xfer(input int src, input int tgt, input logic [31:0] cmd);
        int cnt, w, bl, s, t;
        cnt = int'(cmd[12:0]);
        w  = (cmd[15:14] == 1) ? 1 : (cmd[15:14] == 2) ? 2 : 4;
        bl = (cmd[17:16] == 2) ? 16 : (cmd[17:16] == 3) ? 32 : 8;
        s = src; t = tgt;
        while (cnt > 0) begin
            int chunk, left;
            logic [7:0] bytes[$];
            chunk = (cnt < bl) ? cnt : bl;
            left = chunk;
            while (left > 0) begin
                int n;
                acc_t a;
                n = (left < w) ? left : w;
                a.we = 0; a.addr = s & ~3; a.data = 0; a.be = 0;
                expq.push_back(a);
                for (int k = 0; k < n; k++) bytes.push_back(mbyte(s + k));
                if (cmd[31]) s += n;
                left -= n;
            end
            left = chunk;
            while (left > 0) begin
                int n;
                acc_t a;
                n = (left < w) ? left : w;
                a.we = 1; a.addr = t & ~3; a.data = 0;
                a.be = 4'(((1 << n) - 1) << (t & 3));
                for (int k = 0; k < n; k++) a.data[8*((t & 3) + k) +: 8] = bytes.pop_front();
                expq.push_back(a);
                if (cmd[30]) t += n;
                left -= n;
            end
            cnt -= chunk;
        end
    endtask

    // ---------------- register helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_stop(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            rd(3'd0, v);
            n++;
        end while (!v[3] && n < 20000);
        if (!v[3]) chk(req, v, v | 32'h8);
    endtask

    task automatic chk_copy(input string req, input int src, input int tgt, input int cnt);
        int bad;
        bad = 0;
        for (int i = 0; i < cnt; i++)
            if (mbyte(tgt + i) !== mbyte(src + i)) bad++;
        chk(req, bad, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] v;
        for (int i = 32'h400; i < 32'h600; i++) mem[i] = i * 32'h9E3779B1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v);
        chk("R1 status after reset", v, 32'h0000_0008);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 no request after reset", {31'd0, mem_req}, 32'd0);

        // R7 + R3 + R11: no-descriptor word copy, writes while active ignored
        lat = 2;
        wr(3'd2, 32'h1000);
        wr(3'd3, 32'h2000);
        wr(3'd4, 32'hC022_C028);
        model_xfer(32'h1000, 32'h2000, 32'hC022_C028);
        wr(3'd0, 32'hC000_0000);
        repeat (3) @(negedge clk);
        wr(3'd3, 32'hDEAD_0000);
        wr(3'd4, 32'h0000_0001);
        wait_stop("R7 stopped after direct run");
        chk("R3 all accesses done", expq.size(), 0);
        chk_copy("R3 word copy contents", 32'h1000, 32'h2000, 40);
        rd(3'd0, v);
        chk("R8 end status after direct run", v, 32'h4000_000C);
        chk("R8 irq with end status", {31'd0, irq}, 32'd1);
        rd(3'd4, v);
        chk("R3 count reads zero", v, 32'hC022_C000);
        rd(3'd3, v);
        chk("R11 target write ignored while active", v, 32'h2028);
        wr(3'd0, 32'h4000_0004);
        chk("R8 end cleared by write-one", {31'd0, irq}, 32'd0);

        // R4 byte accesses with lane offsets
        lat = 0;
        wr(3'd2, 32'h1101);
        wr(3'd3, 32'h2203);
        wr(3'd4, 32'hC001_400D);
        model_xfer(32'h1101, 32'h2203, 32'hC001_400D);
        wr(3'd0, 32'hC000_0000);
        wait_stop("R4 byte run stops");
        chk("R4 byte accesses done", expq.size(), 0);
        chk_copy("R4 byte copy contents", 32'h1101, 32'h2203, 13);

        // R4 halfword accesses with a one-byte remainder
        wr(3'd2, 32'h1302);
        wr(3'd3, 32'h2402);
        wr(3'd4, 32'hC001_8007);
        model_xfer(32'h1302, 32'h2402, 32'hC001_8007);
        wr(3'd0, 32'hC000_0000);
        wait_stop("R4 halfword run stops");
        chk("R4 halfword accesses done", expq.size(), 0);
        chk_copy("R4 halfword copy contents", 32'h1302, 32'h2402, 7);

        // R5 fixed target address
        lat = 1;
        wr(3'd2, 32'h1400);
        wr(3'd3, 32'h2500);
        wr(3'd4, 32'h8001_C010);
        model_xfer(32'h1400, 32'h2500, 32'h8001_C010);
        wr(3'd0, 32'hC000_0000);
        wait_stop("R5 fixed-target run stops");
        chk("R5 fixed-target accesses done", expq.size(), 0);
        chk("R5 last word at fixed target", mrd(32'h2500), mrd(32'h140C));
        rd(3'd3, v);
        chk("R5 target did not advance", v, 32'h2500);

        // R2 R6 R13 descriptor chain
        mem[32'h400 >> 2] = 32'h0000_0416; mem[32'h404 >> 2] = 32'h1500;
        mem[32'h408 >> 2] = 32'h2600;      mem[32'h40C >> 2] = 32'hC002_C018;
        mem[32'h410 >> 2] = 32'h0000_0420; mem[32'h414 >> 2] = 32'h1600;
        mem[32'h418 >> 2] = 32'h2700;      mem[32'h41C >> 2] = 32'hC000_4006;
        mem[32'h420 >> 2] = 32'h0000_0001; mem[32'h424 >> 2] = 32'h0;
        mem[32'h428 >> 2] = 32'h0;         mem[32'h42C >> 2] = 32'h0060_0000;
        model_fetch(32'h400);
        model_xfer(32'h1500, 32'h2600, 32'hC002_C018);
        model_fetch(32'h410);
        model_xfer(32'h1600, 32'h2700, 32'hC000_4006);
        model_fetch(32'h420);
        wr(3'd1, 32'h0000_040C);
        wr(3'd0, 32'h8000_0000);
        wait_stop("R6 chain halts on stop flag");
        chk("R2 R6 R13 chain accesses done", expq.size(), 0);
        chk_copy("R6 first descriptor copy", 32'h1500, 32'h2600, 24);
        chk_copy("R6 second descriptor copy", 32'h1600, 32'h2700, 6);
        rd(3'd0, v);
        chk("R13 start and end from empty descriptor", v, 32'h0000_000E);
        rd(3'd1, v);
        chk("R2 last next pointer loaded", v, 32'h0000_0001);
        wr(3'd0, 32'h0000_0006);

        // R9 bus error on first read
        wr(3'd2, 32'h8000);
        wr(3'd3, 32'h2800);
        wr(3'd4, 32'hC000_C010);
        model_xfer(32'h8000, 32'h2800, 32'hC000_C010);
        while (expq.size() > 1) void'(expq.pop_back());
        wr(3'd0, 32'hC000_0000);
        wait_stop("R9 error stops channel");
        repeat (20) @(negedge clk);
        chk("R9 no access after error", expq.size(), 0);
        rd(3'd0, v);
        chk("R9 error status", v, 32'h4000_0009);
        rd(3'd4, v);
        chk("R9 count unchanged", v, 32'hC000_C010);
        chk("R9 irq on error", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h4000_0001);
        rd(3'd0, v);
        chk("R8 error cleared by write-one", v, 32'h4000_0008);

        // R10 software stop mid-transfer
        loose = 1'b1;
        wr(3'd2, 32'h3000);
        wr(3'd3, 32'h5000);
        wr(3'd4, 32'hC023_CFA0);
        wr(3'd0, 32'hC000_0000);
        repeat (40) @(negedge clk);
        wr(3'd0, 32'h4000_0000);
        repeat (8) @(negedge clk);
        loose = 1'b0;
        rd(3'd0, v);
        chk("R10 stopped without end event", v, 32'h4000_0008);
        rd(3'd4, v);
        chk("R10 count left partial", {31'd0, (v[12:0] != 0) && (v[12:0] != 13'd4000)}, 32'd1);
        repeat (20) @(negedge clk);
        chk("R10 no access after stop", {31'd0, mem_req}, 32'd0);

        // R8 stop interrupt enable
        wr(3'd0, 32'h2000_0000);
        chk("R8 stop irq enabled", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h0000_0000);
        chk("R8 stop irq disabled", {31'd0, irq}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule